// File: doc/BRIEF.md
# Repeat-Mode DMA Address Counter

This block is the address and count engine for one DMA channel that runs in repeat mode. It keeps a 24-bit memory-side address and a 16-bit I/O-side address. The top 8 bits of the I/O-side address are always ones. It also keeps two 8-bit count registers: a live counter and a reload holder. Each completed transfer, signalled by a one-cycle strobe, moves the memory address by one element and lowers the live counter by one. When the live counter reaches zero, it is refilled from the holder. In the same cycle the memory address is moved back arithmetically by the block length, so it returns to the start of the block.

Software programs the block through a single write port: a select code, a data word and a write enable. The channel then cycles through its block over and over, with no end event, until the enable bit is cleared. Clearing the enable freezes all state. Setting it again resumes from the next transfer. Two output buses give the current source and destination addresses. A routing bit in the control register places the memory-side address on one bus and the I/O-side address on the other.

Top module: `rdma_repeat_ctr`

## Requirements
- R1: After synchronous reset, the memory address, the I/O low half, both count registers and all control bits are zero. So src_addr reads 0x000000 and dst_addr reads 0xFF0000.
- R2: A cycle with wr_en high loads one register, chosen by wr_sel:
  - 0 loads the memory address from wr_data[23:0].
  - 1 loads the I/O low half from wr_data[15:0].
  - 2 loads the live counter from wr_data[7:0].
  - 3 loads the reload holder from wr_data[7:0].
  - 4 loads the control register from wr_data[3:0]: bit0 enable, bit1 word size, bit2 decrement, bit3 memory-is-destination.
- R3: The I/O-side address on the output is always its 16-bit register with the upper 8 bits set to 0xFF.
- R4: Each enabled strobe changes the memory address by the step, which is 1 for byte size and 2 for word size. The step is added when the decrement bit is 0 and subtracted when it is 1.
- R5: Each enabled strobe lowers the live counter by one. When the counter would reach zero, it is refilled from the holder instead. In that cycle the stepped memory address is also corrected by −(±1)·step·holder, which returns it to the block start.
- R6: A holder or live count of 0 stands for 256 transfers, both for the block length and for the rewind distance.
- R7: A strobe while the enable bit is 0 changes neither address nor counter.
- R8: A strobe in the same cycle as a register write is ignored. Only the write takes effect.
- R9: Clearing the enable bit and setting it again leaves the address and counters untouched, so the block continues where it stopped.
- R10: With the memory-is-destination bit 0, src_addr is the memory address and dst_addr is the I/O-side address. With the bit 1, the two are swapped.
- R11: Memory address arithmetic, including the rewind, wraps modulo 2^24.
- R12: The live counter and holder are not forced to be equal. The first block runs for the live count, and every later block runs for the holder count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 24 | Register write data |
| xfer_done | input | 1 | One transfer completed this cycle |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |

## Verification
The assertions assume that wr_sel carries one of the five defined codes whenever wr_en is high. They also assume that every cycle with xfer_done high stands for exactly one finished transfer, so a strobe held high for several cycles counts as several transfers. The stimulus only ever uses the defined select codes. It pulses the strobe one cycle per intended transfer, and it raises it together with a write only in the case meant to test write priority.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MEM  = 3'd0,
        SEL_IO   = 3'd1,
        SEL_LIVE = 3'd2,
        SEL_HOLD = 3'd3,
        SEL_CTL  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } xfer_size_e;

    localparam int CTL_W = 4;

    typedef struct packed {
        logic       mem_dst;
        logic       dec;
        xfer_size_e size;
        logic       en;
    } chan_ctl_t;

endpackage

// File: rtl/rdma_count_unit.sv
module rdma_count_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_live,
    input  logic             ld_hold,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] hold_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign wrap = tick && (live_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            hold_q <= '0;
        end else begin
            if (ld_live) begin
                live_q <= wdata;
            end else if (tick) begin
                live_q <= wrap ? hold_q : live_q - ONE;
            end
            if (ld_hold) begin
                hold_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/rdma_addr_unit.sv
module rdma_addr_unit
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_mem,
    input  logic              ld_io,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              tick,
    input  logic              wrap,
    input  xfer_size_e        size,
    input  logic              dec,
    input  logic [CNT_W-1:0]  hold,
    output logic [ADDR_W-1:0] mem_q,
    output logic [ADDR_W-1:0] io_full
);
    localparam int HI_W = ADDR_W - IO_W;

    logic [IO_W-1:0]   io_q;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] fwd;
    logic [ADDR_W-1:0] blk_len;
    logic [ADDR_W-1:0] rewind_mag;
    logic [ADDR_W-1:0] rewound;

    always_comb begin
        step       = (size == SZ_WORD) ? ADDR_W'(2) : ADDR_W'(1);
        fwd        = dec ? mem_q - step : mem_q + step;
        blk_len    = (hold == '0) ? (ADDR_W'(1) << CNT_W) : ADDR_W'(hold);
        rewind_mag = (size == SZ_WORD) ? (blk_len << 1) : blk_len;
        rewound    = dec ? fwd + rewind_mag : fwd - rewind_mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
            io_q  <= '0;
        end else begin
            if (ld_mem) begin
                mem_q <= wdata;
            end else if (tick) begin
                mem_q <= wrap ? rewound : fwd;
            end
            if (ld_io) begin
                io_q <= wdata[IO_W-1:0];
            end
        end
    end

    assign io_full = {{HI_W{1'b1}}, io_q};
endmodule

// File: rtl/rdma_repeat_ctr.sv
module rdma_repeat_ctr
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    chan_ctl_t         ctl_q;
    logic              ld_mem, ld_io, ld_live, ld_hold, ld_ctl;
    logic              tick, wrap;
    logic [CNT_W-1:0]  live_q, hold_q;
    logic [ADDR_W-1:0] mem_q, io_full;
    logic              en_w, dec_w, dst_w;
    xfer_size_e        size_w;

    always_comb begin
        ld_mem  = wr_en && (reg_sel_e'(wr_sel) == SEL_MEM);
        ld_io   = wr_en && (reg_sel_e'(wr_sel) == SEL_IO);
        ld_live = wr_en && (reg_sel_e'(wr_sel) == SEL_LIVE);
        ld_hold = wr_en && (reg_sel_e'(wr_sel) == SEL_HOLD);
        ld_ctl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ld_ctl) begin
            ctl_q <= chan_ctl_t'(wr_data[CTL_W-1:0]);
        end
    end

    assign en_w   = ctl_q.en;
    assign dec_w  = ctl_q.dec;
    assign dst_w  = ctl_q.mem_dst;
    assign size_w = ctl_q.size;
    assign tick   = en_w && xfer_done && !wr_en;

    rdma_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ld_live (ld_live),
        .ld_hold (ld_hold),
        .wdata   (wr_data[CNT_W-1:0]),
        .tick    (tick),
        .wrap    (wrap),
        .live_q  (live_q),
        .hold_q  (hold_q)
    );

    rdma_addr_unit #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .ld_mem  (ld_mem),
        .ld_io   (ld_io),
        .wdata   (wr_data),
        .tick    (tick),
        .wrap    (wrap),
        .size    (size_w),
        .dec     (dec_w),
        .hold    (hold_q),
        .mem_q   (mem_q),
        .io_full (io_full)
    );

    assign src_addr = dst_w ? io_full : mem_q;
    assign dst_addr = dst_w ? mem_q : io_full;
endmodule

// File: rtl/rdma_repeat_ctr_chk.sv
module rdma_repeat_ctr_chk #(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic              xfer_done,
    input logic              en,
    input logic              word,
    input logic              dec,
    input logic              mem_dst,
    input logic [ADDR_W-1:0] mem_q,
    input logic [CNT_W-1:0]  live_q,
    input logic [CNT_W-1:0]  hold_q,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr
);
    localparam int HI_W = ADDR_W - IO_W;

    logic              fire, last;
    logic [ADDR_W-1:0] exp_fwd;
    logic [ADDR_W-1:0] io_side;

    assign fire    = en && xfer_done && !wr_en;
    assign last    = (live_q == CNT_W'(1));
    assign exp_fwd = dec ? mem_q - (word ? ADDR_W'(2) : ADDR_W'(1))
                         : mem_q + (word ? ADDR_W'(2) : ADDR_W'(1));
    assign io_side = mem_dst ? src_addr : dst_addr;

    AST_IO_UPPER_ONES: assert property (@(posedge clk) disable iff (rst)
        io_side[ADDR_W-1:IO_W] == {HI_W{1'b1}}); // R3

    AST_STEP_MID: assert property (@(posedge clk) disable iff (rst)
        (fire && !last) |=> (mem_q == $past(exp_fwd))); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (fire && last) |=> (live_q == $past(hold_q))); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !en) |=> ($stable(mem_q) && $stable(live_q))); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0 && xfer_done) |=> (mem_q == $past(wr_data))); // R8

    AST_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (mem_dst ? dst_addr : src_addr) == mem_q); // R10
endmodule

bind rdma_repeat_ctr rdma_repeat_ctr_chk #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .xfer_done (xfer_done),
    .en        (en_w),
    .word      (size_w == rdma_pkg::SZ_WORD),
    .dec       (dec_w),
    .mem_dst   (dst_w),
    .mem_q     (mem_q),
    .live_q    (live_q),
    .hold_q    (hold_q),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr)
);

// File: tb/rdma_repeat_ctr_tb.sv
module rdma_repeat_ctr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [23:0] wr_data = 24'd0;
    logic        xfer_done = 1'b0;
    logic [23:0] src_addr, dst_addr;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    // reference state
    int m_mem, m_io, m_live, m_hold;
    bit m_en, m_word, m_dec, m_dst;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdma_repeat_ctr u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .xfer_done (xfer_done),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mem = 0; m_io = 0; m_live = 0; m_hold = 0;
            m_en = 0; m_word = 0; m_dec = 0; m_dst = 0;
        end else if (wr_en) begin
            case (wr_sel)
                3'd0: m_mem  = int'(wr_data);
                3'd1: m_io   = int'(wr_data[15:0]);
                3'd2: m_live = int'(wr_data[7:0]);
                3'd3: m_hold = int'(wr_data[7:0]);
                3'd4: begin
                    m_en = wr_data[0]; m_word = wr_data[1];
                    m_dec = wr_data[2]; m_dst = wr_data[3];
                end
                default: ;
            endcase
        end else if (xfer_done && m_en) begin
            int stp, len;
            stp = m_word ? 2 : 1;
            m_mem = (m_mem + (m_dec ? -stp : stp)) & 'hFFFFFF;
            m_live = (m_live + 255) % 256;
            if (m_live == 0) begin
                m_live = m_hold;
                len = (m_hold == 0) ? 256 : m_hold;
                m_mem = (m_mem - (m_dec ? -1 : 1) * stp * len) & 'hFFFFFF;
            end
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started) begin
            logic [23:0] e_mem, e_io;
            e_mem = 24'(m_mem);
            e_io  = 24'hFF0000 | 24'(m_io);
            checks++;
            if (src_addr !== (m_dst ? e_io : e_mem) || dst_addr !== (m_dst ? e_mem : e_io)) begin
                failures++;
                $display("FAIL %s per-cycle model: src=%06h dst=%06h expected src=%06h dst=%06h",
                         cur_req, src_addr, dst_addr, m_dst ? e_io : e_mem, m_dst ? e_mem : e_io);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [23:0] d, input logic strobe = 1'b0);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; xfer_done = strobe;
        cyc();
        wr_en = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1'b1;
            cyc();
        end
        xfer_done = 1'b0;
    endtask

    task automatic idle_strobes(input int n);
        strobes(n);
    endtask

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [23:0] mem, input logic [7:0] live,
                         input logic [7:0] hold, input logic [3:0] ctl);
        wr(3'd0, mem);
        wr(3'd2, {16'd0, live});
        wr(3'd3, {16'd0, hold});
        wr(3'd4, {20'd0, ctl});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1 reset values
        chk("R1", src_addr, 24'h000000);
        chk("R1", dst_addr, 24'hFF0000);

        // R2 R3 R4 R5 byte increment, block of 4
        cur_req = "R4";
        wr(3'd1, 24'h002345);
        setup(24'h001000, 8'd4, 8'd4, 4'h1);
        chk("R3", dst_addr, 24'hFF2345);
        chk("R2", src_addr, 24'h001000);
        strobes(3);
        chk("R4", src_addr, 24'h001003);
        cur_req = "R5";
        strobes(1);
        chk("R5", src_addr, 24'h001000);

        // R4 R5 word decrement, block of 3
        setup(24'h000100, 8'd3, 8'd3, 4'h7);
        strobes(1);
        chk("R4", src_addr, 24'h0000FE);
        strobes(2);
        chk("R5", src_addr, 24'h000100);

        // R6 count of zero = 256
        cur_req = "R6";
        setup(24'h002000, 8'd0, 8'd0, 4'h1);
        strobes(255);
        chk("R6", src_addr, 24'h0020FF);
        strobes(1);
        chk("R6", src_addr, 24'h002000);

        // R7 disabled strobes ignored
        cur_req = "R7";
        wr(3'd4, 24'h000000);
        idle_strobes(5);
        chk("R7", src_addr, 24'h002000);

        // R9 pause and resume
        cur_req = "R9";
        setup(24'h003000, 8'd4, 8'd4, 4'h1);
        strobes(2);
        chk("R9", src_addr, 24'h003002);
        wr(3'd4, 24'h000000);
        idle_strobes(3);
        chk("R9", src_addr, 24'h003002);
        wr(3'd4, 24'h000001);
        strobes(2);
        chk("R9", src_addr, 24'h003000);

        // R8 write beats strobe
        cur_req = "R8";
        wr(3'd1, 24'h000777, 1'b1);
        chk("R8", src_addr, 24'h003000);
        chk("R8", dst_addr, 24'hFF0777);

        // R10 routing swap
        cur_req = "R10";
        wr(3'd4, 24'h000009);
        chk("R10", src_addr, 24'hFF0777);
        chk("R10", dst_addr, 24'h003000);
        strobes(1);
        chk("R10", dst_addr, 24'h003001);

        // R11 wrap modulo 2^24
        cur_req = "R11";
        setup(24'hFFFFFF, 8'd2, 8'd2, 4'h1);
        strobes(1);
        chk("R11", src_addr, 24'h000000);
        strobes(1);
        chk("R11", src_addr, 24'hFFFFFF);

        // R12 live and holder differ
        cur_req = "R12";
        setup(24'h004000, 8'd2, 8'd5, 4'h1);
        strobes(2);
        chk("R12", src_addr, 24'h003FFD);
        strobes(4);
        chk("R12", src_addr, 24'h004001);
        strobes(1);
        chk("R12", src_addr, 24'h003FFD);

        cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule